// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of unsigned integers on an N by N grid of multiply-accumulate cells. Each cell owns one element of the product and keeps it in a local accumulator. Rows of the left operand travel rightward across the grid and columns of the right operand travel downward, one cell per clock. Every cell works only on the operands that reach it from its left and upper neighbours.

A one-cycle start pulse clears the grid. The caller then presents one column of the left matrix and one row of the right matrix on each of the next N cycles. The block skews these streams internally, so the caller drives all lanes in the same cycle without offsets. It injects zeros behind the real data until the last cell has done its work.

The finished products are not read out in parallel. They move down the columns one row per cycle and leave through the bottom row of the grid. The bottom row of the product comes out first and row 0 comes out last. A done flag marks the final output word.

Top module: `osys_matmul`

## Requirements
- R1: After reset, and for as long as no start pulse is seen, `res_valid` and `done` stay low whatever values are on the operand inputs.
- R2: Each output word equals the exact unsigned sum over k of A[i][k]*B[k][j], with no loss at ACC_W = 2*W+clog2(N) bits, including all operands at their maximum. Lane i of `a_edge` is bits [i*W +: W] and carries A[i][k]. Lane j of `b_edge` is bits [j*W +: W] and carries B[k][j]. Lane j of `res_row` is bits [j*ACC_W +: ACC_W].
- R3: Let e0 be the rising edge that samples `start`. `res_valid` first goes high in the cycle that follows the 3N-2'th rising edge after e0, and it is low in every cycle before that.
- R4: `res_valid` stays high for exactly N consecutive cycles. During them `res_row` carries product rows N-1, N-2, ... 0, one row per cycle.
- R5: `done` is high for exactly one cycle, the cycle in which row 0 appears, and is low at all other times.
- R6: Operand inputs are used only in the N cycles right after the start edge, where cycle k carries index k. Values driven in any other cycle have no effect on the results.
- R7: A start pulse in the middle of a computation abandons it and clears every accumulator. The results that follow depend only on the operands supplied after the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse: clear the grid and begin accepting operands |
| a_edge | input | N*W | Left-edge operands, lane i = A[i][k] |
| b_edge | input | N*W | Top-edge operands, lane j = B[k][j] |
| res_valid | output | 1 | `res_row` holds one product row |
| res_row | output | N*ACC_W | One product row, lane j = C[r][j] |
| done | output | 1 | Last product row (row 0) is on `res_row` |

## Verification
The hardest case to reach from the ports is an abort: a new start that arrives while old partial sums sit in the accumulators and old operands are still in the skew and link registers. Results after such an abort are wrong only if some of that stale state survives the clear. The bench starts runs with random matrices and then restarts them, once during operand entry and once during the zero-filled tail, before it checks a full run. Every cycle outside the operand window is driven with random values. This shows that nothing sampled outside the window leaks into the sums.

// File: rtl/osys_pkg.sv
package osys_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FEED  = 2'd1,
    SEQ_FLUSH = 2'd2,
    SEQ_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/osys_rst_sync.sv
module osys_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/osys_seq.sv
module osys_seq #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clr,
  output logic feed_en,
  output logic mac_en,
  output logic drain_en,
  output logic res_valid,
  output logic done
);
  import osys_pkg::*;

  localparam int CW = $clog2(2 * N);
  localparam logic [CW-1:0] FEED_LAST  = CW'(N - 1);
  localparam logic [CW-1:0] FLUSH_LAST = CW'(2 * N - 3);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(N - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start) begin
      state_d = SEQ_FEED;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          state_d = SEQ_IDLE;
        end
        SEQ_FEED: begin
          if (cnt_q == FEED_LAST) begin
            state_d = SEQ_FLUSH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_FLUSH: begin
          if (cnt_q == FLUSH_LAST) begin
            state_d = SEQ_DRAIN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_DRAIN: begin
          if (cnt_q == DRAIN_LAST) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clr       = start;
  assign feed_en   = (state_q == SEQ_FEED);
  assign mac_en    = (state_q == SEQ_FEED) || (state_q == SEQ_FLUSH);
  assign drain_en  = (state_q == SEQ_DRAIN);
  assign res_valid = (state_q == SEQ_DRAIN);
  assign done      = (state_q == SEQ_DRAIN) && (cnt_q == DRAIN_LAST);
endmodule

// File: rtl/osys_delay.sv
module osys_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] sr_q [DEPTH];
      logic [W-1:0] sr_d [DEPTH];

      always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
          sr_d[s] = sr_q[s];
        end
        if (clr) begin
          for (int s = 0; s < DEPTH; s++) begin
            sr_d[s] = '0;
          end
        end else if (en) begin
          sr_d[0] = din;
          for (int s = 1; s < DEPTH; s++) begin
            sr_d[s] = sr_q[s-1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < DEPTH; s++) begin
            sr_q[s] <= '0;
          end
        end else begin
          for (int s = 0; s < DEPTH; s++) begin
            sr_q[s] <= sr_d[s];
          end
        end
      end

      assign dout = sr_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/osys_cell.sv
module osys_cell #(
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mac_en,
  input  logic          drain_en,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [AW-1:0] acc_i,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] prod;

  assign prod = AW'(a_i) * AW'(b_i);

  always_comb begin
    acc_d = acc_q;
    if (clr)           acc_d = '0;
    else if (mac_en)   acc_d = acc_q + prod;
    else if (drain_en) acc_d = acc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/osys_matmul.sv
module osys_matmul #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int ACC_W = 2 * W + $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N*W-1:0]     a_edge,
  input  logic [N*W-1:0]     b_edge,
  output logic               res_valid,
  output logic [N*ACC_W-1:0] res_row,
  output logic               done
);
  logic rst_n_int;
  logic clr, feed_en, mac_en, drain_en;

  logic [W-1:0]     a_h [N][N];
  logic [W-1:0]     b_v [N][N];
  logic [ACC_W-1:0] acc [N][N];

  osys_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  osys_seq #(.N(N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .clr       (clr),
    .feed_en   (feed_en),
    .mac_en    (mac_en),
    .drain_en  (drain_en),
    .res_valid (res_valid),
    .done      (done)
  );

  generate
    for (genvar e = 0; e < N; e++) begin : g_edge
      logic [W-1:0] a_feed, b_feed;
      assign a_feed = feed_en ? a_edge[e*W +: W] : '0;
      assign b_feed = feed_en ? b_edge[e*W +: W] : '0;

      osys_delay #(.W(W), .DEPTH(e)) u_skew_a (
        .clk (clk), .rst_n (rst_n_int), .clr (clr), .en (mac_en),
        .din (a_feed), .dout (a_h[e][0])
      );
      osys_delay #(.W(W), .DEPTH(e)) u_skew_b (
        .clk (clk), .rst_n (rst_n_int), .clr (clr), .en (mac_en),
        .din (b_feed), .dout (b_v[0][e])
      );
    end

    for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
        logic [ACC_W-1:0] acc_above;
        if (r == 0) begin : g_top
          assign acc_above = '0;
        end else begin : g_inner
          assign acc_above = acc[r-1][c];
        end

        osys_cell #(.W(W), .AW(ACC_W)) u_cell (
          .clk      (clk),
          .rst_n    (rst_n_int),
          .clr      (clr),
          .mac_en   (mac_en),
          .drain_en (drain_en),
          .a_i      (a_h[r][c]),
          .b_i      (b_v[r][c]),
          .acc_i    (acc_above),
          .acc_o    (acc[r][c])
        );

        if (c < N - 1) begin : g_link_a
          osys_delay #(.W(W), .DEPTH(1)) u_link (
            .clk (clk), .rst_n (rst_n_int), .clr (clr), .en (mac_en),
            .din (a_h[r][c]), .dout (a_h[r][c+1])
          );
        end
        if (r < N - 1) begin : g_link_b
          osys_delay #(.W(W), .DEPTH(1)) u_link (
            .clk (clk), .rst_n (rst_n_int), .clr (clr), .en (mac_en),
            .din (b_v[r][c]), .dout (b_v[r+1][c])
          );
        end
      end
    end

    for (genvar c = 0; c < N; c++) begin : g_out
      assign res_row[c*ACC_W +: ACC_W] = acc[N-1][c];
    end
  endgenerate
endmodule

// File: rtl/osys_matmul_chk.sv
module osys_matmul_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic res_valid,
  input logic done
);
  // R5
  done_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  valid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !done && !start) |=> res_valid);

  // R4
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !res_valid);

  // R3
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !res_valid);

  // R1
  valid_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> !start);
endmodule

bind osys_matmul osys_matmul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .res_valid (res_valid),
  .done      (done)
);

// File: tb/sim_osys_matmul.sv
`timescale 1ns/1ps
module sim_osys_matmul;
  localparam int N     = 4;
  localparam int W     = 8;
  localparam int ACC_W = 2 * W + $clog2(N);
  localparam int IW    = N * W;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [N*W-1:0]     a_edge;
  logic [N*W-1:0]     b_edge;
  logic               res_valid;
  logic [N*ACC_W-1:0] res_row;
  logic               done;

  int checks;
  int fails;
  int cycles;

  logic [W-1:0] ma [N][N];
  logic [W-1:0] mb [N][N];

  osys_matmul #(.N(N), .W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .a_edge    (a_edge),
    .b_edge    (b_edge),
    .res_valid (res_valid),
    .res_row   (res_row),
    .done      (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_elem(input int r, input int c);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(ma[r][k]) * longint'(mb[k][c]);
    return s;
  endfunction

  task automatic drive_garbage();
    a_edge = IW'($urandom);
    b_edge = IW'($urandom);
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        case (mode)
          0: begin ma[i][j] = W'($urandom); mb[i][j] = W'($urandom); end
          1: begin ma[i][j] = '1; mb[i][j] = '1; end
          2: begin ma[i][j] = (i == j) ? W'(1) : '0; mb[i][j] = W'($urandom); end
          default: begin ma[i][j] = W'($urandom); mb[i][j] = '0; end
        endcase
      end
    end
  endtask

  // abort_at = 0 runs and checks a full multiplication; otherwise stop after that cycle.
  task automatic do_run(input int abort_at, input string tag);
    @(negedge clk);
    start = 1'b1;
    drive_garbage();
    for (int n = 1; n <= 4 * N + 1; n++) begin
      @(negedge clk);
      if (abort_at != 0 && n == abort_at) return;
      if (abort_at == 0) begin
        bit exp_v;
        bit exp_d;
        exp_v = (n >= 3 * N - 1) && (n <= 4 * N - 2);
        exp_d = (n == 4 * N - 2);
        chk(res_valid == exp_v, (n <= 3 * N - 1) ? "R3" : "R4",
            $sformatf("res_valid cycle %0d", n), longint'(res_valid), longint'(exp_v));
        chk(done == exp_d, "R5", $sformatf("done cycle %0d", n),
            longint'(done), longint'(exp_d));
        if (exp_v && res_valid) begin
          int r;
          r = 4 * N - 2 - n;
          for (int j = 0; j < N; j++) begin
            longint act;
            act = longint'(res_row[j*ACC_W +: ACC_W]);
            chk(act == ref_elem(r, j), tag, $sformatf("C[%0d][%0d]", r, j),
                act, ref_elem(r, j));
          end
        end
      end
      start = 1'b0;
      if (n <= N) begin
        for (int i = 0; i < N; i++) begin
          a_edge[i*W +: W] = ma[i][n-1];
          b_edge[i*W +: W] = mb[n-1][i];
        end
      end else begin
        drive_garbage();
      end
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL R3 watchdog: actual=%0d expected<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    void'($urandom(32'h5EED));
    rst_n  = 1'b0;
    start  = 1'b0;
    a_edge = '0;
    b_edge = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle with noisy operand inputs
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R1", "res_valid idle", longint'(res_valid), 0);
      chk(done == 1'b0, "R1", "done idle", longint'(done), 0);
      drive_garbage();
    end

    // R2: random, all-max, identity, zero right operand
    fill(0); do_run(0, "R2");
    fill(1); do_run(0, "R2");
    fill(2); do_run(0, "R2");
    fill(3); do_run(0, "R2");

    // R6: random runs with garbage around the operand window
    for (int t = 0; t < 6; t++) begin
      fill(0);
      do_run(0, "R6");
    end

    // R7: abort during operand entry, then during the zero-fill tail
    fill(1); do_run(2, "R7");
    fill(0); do_run(0, "R7");
    fill(1); do_run(N + 2, "R7");
    fill(0); do_run(0, "R7");

    // R1: back to idle after the last run
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R1", "res_valid after runs", longint'(res_valid), 0);
      drive_garbage();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule